// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers up to 32 interrupt request lines into a sticky pending register and masks them with an enable register that software writes. A single interrupt line to the processor goes high while any source is both pending and enabled. A read-only vector word reports which pending, enabled source currently has the highest priority, so the handler needs no bit scan of its own.

Bits are numbered big-end first. Source 0 lives in bit 31 of each word and has the highest priority. Source 31 lives in bit 0 and has the lowest. Request inputs pass through a synchroniser before they set a pending bit. Software clears pending bits by writing ones to them. The register port is plain: an address, write data, a write strobe and combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending word and the enable word are both zero, the processor interrupt is low and the vector reads zero.
- R2: A request on source n, once it has passed the synchroniser, sets pending bit (31 − n). The bit stays set after the request drops, until software clears it.
- R3: The vector is worked out only from sources whose pending bit and enable bit are both 1. A pending source that is not enabled never appears in it.
- R4: When several sources qualify, the vector names the lowest-numbered one, which is the most significant set bit of the masked word.
- R5: The vector word carries a valid flag in bit 5 and the source number in bits 4:0, with all upper bits zero. With no qualifying source the whole word reads zero.
- R6: A write to offset 0 clears every pending bit written as 1 and leaves the pending bits written as 0 unchanged.
- R7: If a pending bit is cleared in the same cycle that its synchronised request is high, the bit stays set.
- R8: The enable word at offset 1 reads back exactly what was written. Clearing an enable bit does not clear the pending bit for that source.
- R9: The processor interrupt is the registered OR of the masked pending word. It rises or falls one clock after the masked word changes.
- R10: Offset 2 returns the vector and ignores writes. Offset 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 32 | Asynchronous request lines; bit 31 − n is source n |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| cpu_irq_o | output | 1 | Interrupt to the processor |

## Verification
Some properties are checked on every cycle by the assertions. Pending bits stay set unless a clear hits them (R2), a synchronised request always wins over a clear in the same cycle (R7), and the enable word changes only on a write to offset 1 (R8). The vector is checked against the masked word for validity and for the absence of any higher-priority set bit (R4, R5). A raised interrupt is checked to follow a valid vector in the cycle before (R9). Other behaviour can only be shown by the bench's scenarios: the bit mapping of each source, the readback of every offset, the ignored writes to offsets 2 and 3, partial clears, and the exact cycle the interrupt rises after an enable write.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PEND   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enable_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] enable;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_mask;

    always_comb begin
        clr_mask = (we_i && addr_i == SEL_PEND) ? wdata_i : '0;
        st_d = st_q;
        if (we_i && addr_i == SEL_ENABLE) begin
            st_d.enable = wdata_i;
        end
        st_d.pend = (st_q.pend & ~clr_mask) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o   = st_q.pend;
    assign enable_o = st_q.enable;

    // R2: a pending bit only drops when a clear hits it
    p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(st_q.pend) & ~$past(clr_mask)) & ~st_q.pend) == '0));

    // R7: a synchronised request always leaves its bit set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(req_i) & ~st_q.pend) == '0));

    // R8: the enable word changes only on a write to its offset
    p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == SEL_ENABLE) |=> $stable(st_q.enable));

endmodule

// File: rtl/prio_irq_encode.sv
module prio_irq_encode #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] masked_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Walk up from the least significant bit so the most significant set bit,
    // the lowest-numbered source, is the last to be written.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int b = 0; b < NUM_SRC; b++) begin
            if (masked_i[b]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(NUM_SRC - 1 - b);
            end
        end
    end

    // R5: a clear valid flag only when nothing qualifies
    always_comb begin
        a_none_r5: assert (valid_o || masked_i == '0);
    end

    // R4: the chosen bit is set and no more significant bit is set
    always_comb begin
        if (valid_o) begin
            a_pick_set_r4: assert (masked_i[NUM_SRC-1-int'(idx_o)]);
            a_pick_top_r4: assert ((masked_i >> (NUM_SRC - int'(idx_o))) == '0 || idx_o == '0);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic               bus_we_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               cpu_irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int VEC_W = IDX_W + 1;

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_SRC-1:0] req_sync;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] masked;
    logic               vec_valid;
    logic [IDX_W-1:0]   vec_idx;
    logic [VEC_W-1:0]   vec_word;

    prio_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_src_i),
        .sync_o  (req_sync)
    );

    prio_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_sync),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i[NUM_SRC-1:0]),
        .pend_o   (pend),
        .enable_o (enable)
    );

    assign masked = pend & enable;

    prio_irq_encode #(.NUM_SRC(NUM_SRC)) u_enc (
        .masked_i (masked),
        .valid_o  (vec_valid),
        .idx_o    (vec_idx)
    );

    assign vec_word = {vec_valid, vec_idx};

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq_o = st_q.irq;

    always_comb begin
        unique case (reg_sel_e'(bus_addr_i))
            SEL_PEND:   bus_rdata_o = DATA_W'(pend);
            SEL_ENABLE: bus_rdata_o = DATA_W'(enable);
            SEL_VECTOR: bus_rdata_o = DATA_W'(vec_word);
            default:    bus_rdata_o = '0;
        endcase
    end

    // R9: a raised interrupt follows a valid vector one cycle earlier
    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> $past(vec_valid));

    // R9: a valid vector raises the interrupt on the next cycle
    p_irq_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> cpu_irq_o);

endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    localparam int NS = 32;
    localparam int NV = 8;

    // {source pattern, enable, expected vector word}
    localparam logic [95:0] VECS [NV] = '{
        {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0020},
        {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_003F},
        {32'h0001_0100, 32'hFFFF_FFFF, 32'h0000_002F},
        {32'h0001_0100, 32'h0000_0100, 32'h0000_0037},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        {32'h0F00_0000, 32'h0300_0000, 32'h0000_0026},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h4000_0000, 32'h8000_0000, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_src_i = '0;
    logic [1:0]    bus_addr_i = '0;
    logic [31:0]   bus_wdata_i = '0;
    logic          bus_we_i = 1'b0;
    logic [31:0]   bus_rdata_o;
    logic          cpu_irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (irq_src_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_we_i    (bus_we_i),
        .bus_rdata_o (bus_rdata_o),
        .cpu_irq_o   (cpu_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_we_i    = 1'b1;
        @(negedge clk);
        bus_we_i    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [NS-1:0] p);
        @(negedge clk);
        irq_src_i = p;
        @(negedge clk);
        irq_src_i = '0;
        idle(4);
    endtask

    task automatic wipe();
        irq_src_i = '0;
        idle(4);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, r); check("R1 pending", r, 32'h0);
        rd(2'd1, r); check("R1 enable", r, 32'h0);
        rd(2'd2, r); check("R1 vector", r, 32'h0);
        check("R1 irq", {31'h0, cpu_irq_o}, 32'h0);

        // table walk: R2 R3 R4 R5 R8 R9
        for (int k = 0; k < NV; k++) begin
            wipe();
            wr(2'd1, VECS[k][63:32]);
            pulse(VECS[k][95:64]);
            rd(2'd0, r); check("R2 pending latch", r, VECS[k][95:64]);
            rd(2'd1, r); check("R8 enable readback", r, VECS[k][63:32]);
            rd(2'd2, r); check("R4 R5 vector", r, VECS[k][31:0]);
            check("R9 irq level", {31'h0, cpu_irq_o}, {31'h0, VECS[k][31:0] != 0});
        end

        // R3: pending but disabled source stays out of the vector
        wipe();
        wr(2'd1, 32'h4000_0000);
        pulse(32'hC000_0000);
        rd(2'd2, r); check("R3 masked vector", r, 32'h0000_0021);

        // R6: partial clear
        wr(2'd0, 32'h4000_0000);
        rd(2'd0, r); check("R6 partial clear", r, 32'h8000_0000);
        wr(2'd0, 32'h0);
        rd(2'd0, r); check("R6 zero write keeps", r, 32'h8000_0000);

        // R8: disabling keeps pending; R9 irq timing
        wr(2'd1, 32'h0);
        idle(1);
        rd(2'd0, r); check("R8 pending kept", r, 32'h8000_0000);
        rd(2'd2, r); check("R8 vector while disabled", r, 32'h0);
        check("R9 irq low when disabled", {31'h0, cpu_irq_o}, 32'h0);
        wr(2'd1, 32'h8000_0000);
        check("R9 irq not yet", {31'h0, cpu_irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq one cycle later", {31'h0, cpu_irq_o}, 32'h1);
        rd(2'd2, r); check("R8 vector after re-enable", r, 32'h0000_0020);

        // R10: vector and spare offsets ignore writes
        rd(2'd2, v);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r); check("R10 vector write ignored", r, v);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, r); check("R10 spare reads zero", r, 32'h0);
        rd(2'd0, r); check("R10 spare write leaves pending", r, 32'h8000_0000);
        rd(2'd1, r); check("R10 spare write leaves enable", r, 32'h8000_0000);

        // R7: request held high wins over a clear
        wipe();
        irq_src_i = 32'h0000_0001;
        idle(4);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, r); check("R7 set wins", r, 32'h0000_0001);
        irq_src_i = '0;
        idle(4);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, r); check("R6 clear after request drops", r, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule